// File: doc/BRIEF.md
# Wallace Tree Multiplier, 8x8 Unsigned

This block multiplies two unsigned 8-bit operands and returns their 16-bit product in a single combinational path. It builds eight partial-product rows, one for each multiplier bit. A tree of 3:2 carry-save adders then reduces those rows level by level, so the critical path grows with the number of tree levels rather than with the number of rows. After four reduction levels only two vectors remain, and a ripple-carry adder sums them into the product.

The datapath uses only bitwise logic. Every sum comes from full-adder equations, and no arithmetic operator is used. The save and carry vectors that leave the third and fourth reduction levels (levels 2 and 3) are also brought out as ports, so an integrating block or a checker can observe the intermediate state of the tree. Every carry vector on those ports is already aligned: it is shifted left by one position, so each bit stands at its true weight.

Top module: `wallace_mult8`

## Requirements
- R1: `product` equals the unsigned product of `mcand` and `mplier` for every one of the 65536 operand pairs.
- R2: Partial product k is `mcand` ANDed with multiplier bit k, zero-extended to 16 bits and shifted left by k. A multiplier with only bit k set therefore yields `mcand` shifted left by k.
- R3: Every carry-save adder forms save = x XOR y XOR z and carry = majority(x, y, z), bit by bit. Its carry output is shifted left by one, so bit 0 of every carry vector is 0 and the bit carried out of position 15 is dropped.
- R4: Level 0 reduces rows (0, 1, 2) and rows (3, 4, 5). Level 1 reduces (save, carry, save) of the first and second level-0 adders, and separately reduces (carry of the second level-0 adder, row 6, row 7).
- R5: Level 2 reduces (save and carry of the first level-1 adder, save of the second level-1 adder). Its results drive `lvl2_save` and `lvl2_carry`.
- R6: Level 3 reduces (`lvl2_save`, `lvl2_carry`, carry of the second level-1 adder). Its results drive `lvl3_save` and `lvl3_carry`.
- R7: A 16-bit ripple-carry adder adds `lvl3_save` and `lvl3_carry`, discards its carry out, and drives `product`.
- R8: When either operand is zero, `product` and all four level outputs are zero.
- R9: The largest operands, 255 x 255, give 0xFE01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mcand | input | 8 | Unsigned multiplicand |
| mplier | input | 8 | Unsigned multiplier |
| product | output | 16 | Unsigned product |
| lvl2_save | output | 16 | Save vector of reduction level 2 |
| lvl2_carry | output | 16 | Aligned carry vector of reduction level 2 |
| lvl3_save | output | 16 | Save vector of reduction level 3 |
| lvl3_carry | output | 16 | Aligned carry vector of reduction level 3 |

## Verification
The bench sweeps every operand pair. It compares the product and the four level vectors against a model built from the requirements, so a design that wires a row into the wrong adder is caught on the level ports even when the final product happens to match. A missing carry shift gives carries the wrong weight, which shows up as a set bit 0 on the carry ports and a wrong product for almost any operands. One-hot multipliers expose partial rows that are misplaced or shifted by the wrong amount. A zero operand catches rows that leak constants, and 255 x 255 drives the longest ripple chain, so a ripple adder that drops an internal carry fails there. A final adder that lets its carry out wrap into bit 0 would also fail on these cases.

// File: rtl/wtm_pkg.sv
package wtm_pkg;
    localparam int OP_W   = 8;
    localparam int PROD_W = 2 * OP_W;

    typedef logic [PROD_W-1:0] word_t;

    typedef struct packed {
        word_t save;
        word_t carry;
    } csa_pair_t;
endpackage

// File: rtl/wtm_ppgen.sv
module wtm_ppgen
    import wtm_pkg::*;
(
    input  logic [OP_W-1:0] mcand,
    input  logic [OP_W-1:0] mplier,
    output word_t           rows [OP_W]
);
    // One row per multiplier bit: gate the multiplicand, widen, move to weight k.
    for (genvar k = 0; k < OP_W; k++) begin : g_row
        assign rows[k] = word_t'({{OP_W{1'b0}}, mcand & {OP_W{mplier[k]}}}) << k;
    end
endmodule

// File: rtl/wtm_csa.sv
module wtm_csa #(
    parameter int W = 16
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic [W-1:0] z,
    output logic [W-1:0] save,
    output logic [W-1:0] carry
);
    // Carry leaves already aligned to its real weight; the overflow bit is dropped.
    assign save  = x ^ y ^ z;
    assign carry = ((x & y) | (x & z) | (y & z)) << 1;
endmodule

// File: rtl/wtm_rca.sv
module wtm_rca #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum
);
    logic [W-1:0] cy;

    assign cy[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum[i] = a[i] ^ b[i] ^ cy[i];
        if (i < W - 1) begin : g_cy
            assign cy[i+1] = (a[i] & b[i]) | (a[i] & cy[i]) | (b[i] & cy[i]);
        end
    end
endmodule

// File: rtl/wallace_mult8.sv
module wallace_mult8
    import wtm_pkg::*;
(
    input  logic [OP_W-1:0]   mcand,
    input  logic [OP_W-1:0]   mplier,
    output logic [PROD_W-1:0] product,
    output logic [PROD_W-1:0] lvl2_save,
    output logic [PROD_W-1:0] lvl2_carry,
    output logic [PROD_W-1:0] lvl3_save,
    output logic [PROD_W-1:0] lvl3_carry
);
    word_t     rows [OP_W];
    csa_pair_t l0a_q, l0b_q, l1a_q, l1b_q, l2_q, l3_q;

    wtm_ppgen u_ppgen (
        .mcand  (mcand),
        .mplier (mplier),
        .rows   (rows)
    );

    // Level 0: six rows into four vectors
    wtm_csa #(.W(PROD_W)) u_l0a (
        .x(rows[0]), .y(rows[1]), .z(rows[2]),
        .save(l0a_q.save), .carry(l0a_q.carry)
    );
    wtm_csa #(.W(PROD_W)) u_l0b (
        .x(rows[3]), .y(rows[4]), .z(rows[5]),
        .save(l0b_q.save), .carry(l0b_q.carry)
    );

    // Level 1: four level-0 vectors plus rows 6 and 7
    wtm_csa #(.W(PROD_W)) u_l1a (
        .x(l0a_q.save), .y(l0a_q.carry), .z(l0b_q.save),
        .save(l1a_q.save), .carry(l1a_q.carry)
    );
    wtm_csa #(.W(PROD_W)) u_l1b (
        .x(l0b_q.carry), .y(rows[6]), .z(rows[7]),
        .save(l1b_q.save), .carry(l1b_q.carry)
    );

    // Level 2: three of the four level-1 vectors
    wtm_csa #(.W(PROD_W)) u_l2 (
        .x(l1a_q.save), .y(l1a_q.carry), .z(l1b_q.save),
        .save(l2_q.save), .carry(l2_q.carry)
    );

    // Level 3: level-2 pair plus the leftover level-1 carry
    wtm_csa #(.W(PROD_W)) u_l3 (
        .x(l2_q.save), .y(l2_q.carry), .z(l1b_q.carry),
        .save(l3_q.save), .carry(l3_q.carry)
    );

    wtm_rca #(.W(PROD_W)) u_rca (
        .a   (l3_q.save),
        .b   (l3_q.carry),
        .sum (product)
    );

    assign lvl2_save  = l2_q.save;
    assign lvl2_carry = l2_q.carry;
    assign lvl3_save  = l3_q.save;
    assign lvl3_carry = l3_q.carry;
endmodule

// File: rtl/wallace_mult8_chk.sv
module wallace_mult8_chk
    import wtm_pkg::*;
(
    input logic [OP_W-1:0]   mcand,
    input logic [OP_W-1:0]   mplier,
    input logic [PROD_W-1:0] product,
    input logic [PROD_W-1:0] lvl2_save,
    input logic [PROD_W-1:0] lvl2_carry,
    input logic [PROD_W-1:0] lvl3_save,
    input logic [PROD_W-1:0] lvl3_carry
);
    always_comb begin
        assert_product_R1: assert (product == ({{OP_W{1'b0}}, mcand} * {{OP_W{1'b0}}, mplier}))
            else $error("R1 product mismatch");
        assert_final_sum_R7: assert (PROD_W'(lvl3_save + lvl3_carry) == product)
            else $error("R7 final adder mismatch");
        assert_carry_lsb_R3: assert (lvl2_carry[0] == 1'b0 && lvl3_carry[0] == 1'b0)
            else $error("R3 carry not aligned");
        assert_l3_majority_R6: assert (((lvl3_carry >> 1) & ~(lvl2_save | lvl2_carry)) == '0)
            else $error("R6 level-3 carry without level-2 support");
        assert_l3_full_R6: assert (((lvl3_carry >> 1) & lvl3_save[PROD_W-2:0]
                                    & ~(lvl2_save & lvl2_carry)) == '0)
            else $error("R6 level-3 all-ones case inconsistent");
        assert_zero_op_R8: assert (!(mcand == '0 || mplier == '0) ||
                                   (product == '0 && lvl2_save == '0 && lvl2_carry == '0 &&
                                    lvl3_save == '0 && lvl3_carry == '0))
            else $error("R8 zero operand leaks");
    end
endmodule

bind wallace_mult8 wallace_mult8_chk u_chk (
    .mcand      (mcand),
    .mplier     (mplier),
    .product    (product),
    .lvl2_save  (lvl2_save),
    .lvl2_carry (lvl2_carry),
    .lvl3_save  (lvl3_save),
    .lvl3_carry (lvl3_carry)
);

// File: tb/wallace_mult8_tb.sv
module wallace_mult8_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  mcand = '0;
    logic [7:0]  mplier = '0;
    logic [15:0] product, lvl2_save, lvl2_carry, lvl3_save, lvl3_carry;
    int          n_checks = 0;
    int          n_errors = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    wallace_mult8 u_dut (
        .mcand      (mcand),
        .mplier     (mplier),
        .product    (product),
        .lvl2_save  (lvl2_save),
        .lvl2_carry (lvl2_carry),
        .lvl3_save  (lvl3_save),
        .lvl3_carry (lvl3_carry)
    );

    // {mcand, mplier, expected product}
    localparam logic [31:0] VEC [8] = '{
        {8'd3,   8'd5,   16'h000F},
        {8'd255, 8'd255, 16'hFE01},
        {8'd0,   8'd200, 16'h0000},
        {8'd17,  8'd0,   16'h0000},
        {8'd128, 8'd128, 16'h4000},
        {8'd255, 8'd1,   16'h00FF},
        {8'd1,   8'd255, 16'h00FF},
        {8'd170, 8'd85,  16'h3872}
    };

    typedef struct {
        logic [15:0] s2, c2, s3, c3;
    } ref_t;

    function automatic void ref_csa(input logic [15:0] x, y, z,
                                    output logic [15:0] s, c);
        s = x ^ y ^ z;
        c = ((x & y) | (x & z) | (y & z)) << 1;
    endfunction

    function automatic ref_t ref_tree(input logic [7:0] a, b);
        logic [15:0] r [8];
        logic [15:0] s0a, c0a, s0b, c0b, s1a, c1a, s1b, c1b;
        ref_t o;
        for (int k = 0; k < 8; k++) r[k] = {8'h00, a & {8{b[k]}}} << k;
        ref_csa(r[0], r[1], r[2], s0a, c0a);
        ref_csa(r[3], r[4], r[5], s0b, c0b);
        ref_csa(s0a, c0a, s0b, s1a, c1a);
        ref_csa(c0b, r[6], r[7], s1b, c1b);
        ref_csa(s1a, c1a, s1b, o.s2, o.c2);
        ref_csa(o.s2, o.c2, c1b, o.s3, o.c3);
        return o;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s a=%0d b=%0d actual=%h expected=%h", req, mcand, mplier, act, exp);
        end
    endtask

    task automatic apply(input logic [7:0] a, input logic [7:0] b);
        @(posedge clk);
        mcand  <= a;
        mplier <= b;
        @(negedge clk);
    endtask

    task automatic check_levels(input logic [7:0] a, input logic [7:0] b);
        ref_t m;
        m = ref_tree(a, b);
        check("R1 product", product, 16'({8'h00, a} * {8'h00, b}));
        check("R5 lvl2_save (R4 R3)", lvl2_save, m.s2);
        check("R5 lvl2_carry (R4 R3)", lvl2_carry, m.c2);
        check("R6 lvl3_save", lvl3_save, m.s3);
        check("R6 lvl3_carry", lvl3_carry, m.c3);
        check("R7 product=lvl3 sum", product, 16'(lvl3_save + lvl3_carry));
    endtask

    initial begin
        // Reset state: zero operands give zero everywhere (R8)
        repeat (2) @(negedge clk);
        check("R8 reset product", product, 16'h0000);
        check("R8 reset lvl2_save", lvl2_save, 16'h0000);
        check("R8 reset lvl3_carry", lvl3_carry, 16'h0000);
        rst_n = 1'b1;

        // Vector table
        for (int v = 0; v < 8; v++) begin
            apply(VEC[v][31:24], VEC[v][23:16]);
            check("R1 table", product, VEC[v][15:0]);
        end

        // R9: largest operands
        apply(8'd255, 8'd255);
        check("R9 max operands", product, 16'hFE01);
        check_levels(8'd255, 8'd255);

        // R2: one-hot multiplier places the multiplicand at weight k
        for (int k = 0; k < 8; k++) begin
            apply(8'hB7, 8'(1 << k));
            check("R2 one-hot row", product, 16'({8'h00, 8'hB7} << k));
        end

        // R8: zero operand on each side
        apply(8'd0, 8'd255);
        check("R8 zero a product", product, 16'h0000);
        check("R8 zero a lvl2_carry", lvl2_carry, 16'h0000);
        check("R8 zero a lvl3_save", lvl3_save, 16'h0000);
        apply(8'd255, 8'd0);
        check("R8 zero b product", product, 16'h0000);
        check("R8 zero b lvl2_save", lvl2_save, 16'h0000);
        check("R8 zero b lvl3_carry", lvl3_carry, 16'h0000);

        // R3: carry vectors are aligned (bit 0 clear) on a dense pattern
        apply(8'hFF, 8'hAA);
        check("R3 lvl2_carry bit0", {15'd0, lvl2_carry[0]}, 16'h0000);
        check("R3 lvl3_carry bit0", {15'd0, lvl3_carry[0]}, 16'h0000);

        // Exhaustive sweep (R1, R4, R5, R6, R7)
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
                apply(8'(a), 8'(b));
                check_levels(8'(a), 8'(b));
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule